// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block turns an address request into a segment offset. A request names an optional base register, an optional index register, a scale code and a 32-bit displacement. The block reads the named registers through two read ports of an eight-entry, 32-bit register file. It adds the displacement, the base value and the index value shifted left by the scale. The result is registered and presented one clock after the request, along with the default segment the offset belongs to and an error flag.

The default segment depends only on which register is the base. If the base is the stack pointer or the frame pointer, the stack segment is used. Every other case uses the data segment, including a frame-pointer index and a request with no base at all. Naming the stack pointer as the index is an illegal form. In real mode, any offset that does not fit in 16 bits is flagged as an error instead of being wrapped. In protected mode the sum wraps modulo 2^32.

Top module: `ea_gen`

## Requirements
- R1: One cycle after `req_valid` is high, `res_offset` equals (displacement + base value + scaled index value) modulo 2^32. The displacement and register values are unsigned.
- R2: The scale code multiplies the index value: code 0 gives ×1, code 1 gives ×2, code 2 gives ×4 and code 3 gives ×8.
- R3: An operand whose valid bit is low adds 0. When `index_valid` is low, the scale code has no effect. When both are low, the offset is the displacement alone.
- R4: The same register may be both base and index. Its value is then counted once as the base and once, scaled, as the index.
- R5: Register selector encoding is 0=A, 1=C, 2=D, 3=B, 4=stack pointer, 5=frame pointer, 6=source index, 7=destination index. `res_stack_seg` is 1 when the base is valid and its selector is 4 or 5.
- R6: `res_stack_seg` is 0 in all other cases: a base of 0–3 or 6–7, no base, and a stack pointer or frame pointer used only as the index.
- R7: A valid index with selector 4 sets `res_error`, in either mode.
- R8: When `real_mode` is 1, `res_error` is set if the full unwrapped sum is above FFFFh. A sum of exactly FFFFh gives no error.
- R9: When `real_mode` is 0, a sum above 2^32−1 wraps with no error, unless R7 applies.
- R10: `res_valid` follows `req_valid` with one cycle of latency. When no request is made, `res_offset`, `res_stack_seg` and `res_error` hold their previous values.
- R11: A synchronous reset clears `res_valid`, `res_offset`, `res_stack_seg` and `res_error` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| real_mode | input | 1 | 1 = 16-bit real-mode range check, 0 = protected (wrapping) |
| base_valid | input | 1 | Base register present |
| base_sel | input | 3 | Base register selector |
| index_valid | input | 1 | Index register present |
| index_sel | input | 3 | Index register selector |
| scale | input | 2 | Index scale code |
| disp | input | 32 | Displacement |
| rf_addr_a | output | 3 | Register file read address, base port |
| rf_addr_b | output | 3 | Register file read address, index port |
| rf_data_a | input | 32 | Register file read data, base port (combinational) |
| rf_data_b | input | 32 | Register file read data, index port (combinational) |
| res_valid | output | 1 | Result valid |
| res_offset | output | 32 | Effective offset |
| res_stack_seg | output | 1 | 1 = stack segment default, 0 = data segment |
| res_error | output | 1 | Illegal index or real-mode range violation |

## Verification
The bench checks both worked examples: 1000h + 4×4 + 8 gives 1018h, and 1000h used as base and as ×2 index plus 1000h gives 4000h. A design that swapped the two read ports, or shifted by the wrong amount, would get different values. It tests the segment choice with the frame pointer as base and as index, with the stack pointer as base, and with no base. A design that keyed the segment on either register would mark the frame-pointer-index case as stack. It sends a stack-pointer index in protected mode, where only the legality check can raise the error. It drives real-mode sums of exactly FFFFh and 10000h to find an off-by-one limit, and a protected-mode sum that carries past 2^32 to catch a design that flags or saturates instead of wrapping. Idle gaps between requests show whether the outputs hold their values.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;
    localparam int XLEN    = 32;
    localparam int NREGS   = 8;
    localparam int SEL_W   = $clog2(NREGS);
    localparam int SCALE_W = 2;
    localparam int NSCALE  = 1 << SCALE_W;
    localparam int MAXSH   = NSCALE - 1;
    localparam int SCW     = XLEN + MAXSH;
    localparam int SUM_W   = XLEN + MAXSH + 1;
    localparam int REAL_W  = 16;

    localparam logic [SEL_W-1:0] SEL_SP = SEL_W'(4);
    localparam logic [SEL_W-1:0] SEL_BP = SEL_W'(5);

    typedef logic [SEL_W-1:0] reg_sel_t;

    typedef enum logic {SEG_DATA = 1'b0, SEG_STACK = 1'b1} seg_e;

    typedef struct packed {
        logic                real_mode;
        logic                base_valid;
        reg_sel_t            base_sel;
        logic                index_valid;
        reg_sel_t            index_sel;
        logic [SCALE_W-1:0]  scale;
        logic [XLEN-1:0]     disp;
    } ea_req_t;

    typedef struct packed {
        logic [XLEN-1:0] offset;
        seg_e            seg;
        logic            error;
    } ea_res_t;

    function automatic seg_e pick_segment(input logic bv, input reg_sel_t bsel);
        return (bv && (bsel == SEL_SP || bsel == SEL_BP)) ? SEG_STACK : SEG_DATA;
    endfunction

    function automatic logic index_illegal(input logic iv, input reg_sel_t isel);
        return iv && (isel == SEL_SP);
    endfunction
endpackage

// File: rtl/ea_operand_fetch.sv
`timescale 1ns/1ps
module ea_operand_fetch
    import ea_pkg::*;
(
    input  ea_req_t              req,
    output reg_sel_t             rd_addr_base,
    output reg_sel_t             rd_addr_index,
    input  logic [XLEN-1:0]      rd_data_base,
    input  logic [XLEN-1:0]      rd_data_index,
    output logic [XLEN-1:0]      base_term,
    output logic [SCW-1:0]       index_term
);
    logic [SCW-1:0] shifted [NSCALE];

    assign rd_addr_base  = req.base_sel;
    assign rd_addr_index = req.index_sel;

    assign base_term = req.base_valid ? rd_data_base : '0;

    // one candidate per scale code
    for (genvar k = 0; k < NSCALE; k++) begin : g_scale
        assign shifted[k] = {{MAXSH{1'b0}}, rd_data_index} << k;
    end

    assign index_term = req.index_valid ? shifted[req.scale] : '0;
endmodule

// File: rtl/ea_adder.sv
`timescale 1ns/1ps
module ea_adder
    import ea_pkg::*;
(
    input  logic [XLEN-1:0]  disp,
    input  logic [XLEN-1:0]  base_term,
    input  logic [SCW-1:0]   index_term,
    output logic [SUM_W-1:0] sum
);
    logic [SUM_W-1:0] d_ext, b_ext, i_ext;

    assign d_ext = SUM_W'(disp);
    assign b_ext = SUM_W'(base_term);
    assign i_ext = SUM_W'(index_term);
    assign sum   = d_ext + b_ext + i_ext;
endmodule

// File: rtl/ea_classify.sv
`timescale 1ns/1ps
module ea_classify
    import ea_pkg::*;
(
    input  ea_req_t          req,
    input  logic [SUM_W-1:0] sum,
    output ea_res_t          res
);
    logic bad_index, out_of_range;

    assign bad_index    = index_illegal(req.index_valid, req.index_sel);
    assign out_of_range = req.real_mode && (|sum[SUM_W-1:REAL_W]);

    always_comb begin
        res.offset = sum[XLEN-1:0];
        res.seg    = pick_segment(req.base_valid, req.base_sel);
        res.error  = bad_index || out_of_range;
    end
endmodule

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen
    import ea_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                real_mode,
    input  logic                base_valid,
    input  logic [SEL_W-1:0]    base_sel,
    input  logic                index_valid,
    input  logic [SEL_W-1:0]    index_sel,
    input  logic [SCALE_W-1:0]  scale,
    input  logic [XLEN-1:0]     disp,
    output logic [SEL_W-1:0]    rf_addr_a,
    output logic [SEL_W-1:0]    rf_addr_b,
    input  logic [XLEN-1:0]     rf_data_a,
    input  logic [XLEN-1:0]     rf_data_b,
    output logic                res_valid,
    output logic [XLEN-1:0]     res_offset,
    output logic                res_stack_seg,
    output logic                res_error
);
    ea_req_t          req;
    logic [XLEN-1:0]  base_term;
    logic [SCW-1:0]   index_term;
    logic [SUM_W-1:0] sum;
    ea_res_t          res_d, res_q;
    logic             valid_q;

    always_comb begin
        req.real_mode   = real_mode;
        req.base_valid  = base_valid;
        req.base_sel    = base_sel;
        req.index_valid = index_valid;
        req.index_sel   = index_sel;
        req.scale       = scale;
        req.disp        = disp;
    end

    ea_operand_fetch u_fetch (
        .req           (req),
        .rd_addr_base  (rf_addr_a),
        .rd_addr_index (rf_addr_b),
        .rd_data_base  (rf_data_a),
        .rd_data_index (rf_data_b),
        .base_term     (base_term),
        .index_term    (index_term)
    );

    ea_adder u_add (
        .disp       (disp),
        .base_term  (base_term),
        .index_term (index_term),
        .sum        (sum)
    );

    ea_classify u_cls (
        .req (req),
        .sum (sum),
        .res (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) res_q <= res_d;
        end
    end

    assign res_valid     = valid_q;
    assign res_offset    = res_q.offset;
    assign res_stack_seg = (res_q.seg == SEG_STACK);
    assign res_error     = res_q.error;

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && $stable(res_offset) && $stable(res_error)));
    // R7
    sp_index_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && index_valid && index_sel == SEL_SP) |=> res_error);
    // R6
    no_base_seg_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !base_valid) |=> !res_stack_seg);
    // R9
    prot_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !real_mode && !(index_valid && index_sel == SEL_SP)) |=> !res_error);
    // R3
    disp_only_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !base_valid && !index_valid) |=> (res_offset == $past(disp)));
endmodule

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, real_mode = 1'b0;
    logic        base_valid = 1'b0, index_valid = 1'b0;
    logic [2:0]  base_sel = '0, index_sel = '0;
    logic [1:0]  scale = '0;
    logic [31:0] disp = '0;
    logic [2:0]  rf_addr_a, rf_addr_b;
    logic [31:0] rf_data_a, rf_data_b;
    logic        res_valid, res_stack_seg, res_error;
    logic [31:0] res_offset;

    logic [31:0] regs [8];
    assign rf_data_a = regs[rf_addr_a];
    assign rf_data_b = regs[rf_addr_b];

    int total = 0, bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] off;
        logic        stk;
        logic        err;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    ea_gen uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .real_mode(real_mode),
        .base_valid(base_valid), .base_sel(base_sel), .index_valid(index_valid),
        .index_sel(index_sel), .scale(scale), .disp(disp),
        .rf_addr_a(rf_addr_a), .rf_addr_b(rf_addr_b),
        .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
        .res_valid(res_valid), .res_offset(res_offset),
        .res_stack_seg(res_stack_seg), .res_error(res_error)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input string tag, input logic rm, input logic bv, input int b,
                        input logic iv, input int i, input int sc, input logic [31:0] d);
        logic [63:0] sum;
        exp_t e;
        @(posedge clk); #1;
        req_valid = 1; real_mode = rm; base_valid = bv; base_sel = 3'(b);
        index_valid = iv; index_sel = 3'(i); scale = 2'(sc); disp = d;
        sum = 64'(d) + (bv ? 64'(regs[b]) : 64'd0) + (iv ? (64'(regs[i]) << sc) : 64'd0);
        e.off = sum[31:0];
        e.stk = bv && (b == 4 || b == 5);
        e.err = (iv && i == 4) || (rm && sum > 64'hFFFF);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            req_valid = 0; disp = 32'hDEAD_BEEF; base_sel = 3'd7;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (q.size() == 0) begin
                check("R10 unexpected res_valid", 64'(res_valid), 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " offset"}, 64'(res_offset), 64'(e.off));
                check({e.tag, " stack_seg"}, 64'(res_stack_seg), 64'(e.stk));
                check({e.tag, " error"}, 64'(res_error), 64'(e.err));
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        regs[0] = 32'h0000_0010; regs[1] = 32'h0000_0100;
        regs[2] = 32'hFFFF_FFFF; regs[3] = 32'h0000_1000;
        regs[4] = 32'h0000_2000; regs[5] = 32'h0000_3000;
        regs[6] = 32'h0000_0004; regs[7] = 32'h0000_7FF0;
        repeat (3) @(posedge clk);
        #1; rst = 0;
        @(negedge clk);
        // R11 reset state
        check("R11 res_valid", 64'(res_valid), 0);
        check("R11 res_offset", 64'(res_offset), 0);
        check("R11 res_stack_seg", 64'(res_stack_seg), 0);
        check("R11 res_error", 64'(res_error), 0);

        send("R1 R2 example 1018h", 1, 1, 3, 1, 6, 2, 32'h8);
        send("R4 same reg 4000h", 1, 1, 3, 1, 3, 1, 32'h1000);
        send("R2 scale x8 index only", 0, 0, 0, 1, 6, 3, 32'h20);
        send("R2 scale x1", 0, 1, 0, 1, 1, 0, 32'h0);
        send("R3 register indirect", 0, 1, 7, 0, 6, 3, 32'h0);
        send("R3 displacement only", 0, 0, 4, 0, 4, 3, 32'h1234_5678);
        idle(2);
        send("R5 frame ptr base", 0, 1, 5, 1, 0, 0, 32'h4);
        send("R5 stack ptr base", 0, 1, 4, 0, 0, 0, 32'h8);
        send("R6 frame ptr as index", 0, 1, 0, 1, 5, 0, 32'h0);
        send("R6 no base frame ptr index", 0, 0, 5, 1, 5, 1, 32'h0);
        send("R7 sp index protected", 0, 1, 1, 1, 4, 0, 32'h0);
        send("R7 sp index real", 1, 0, 0, 1, 4, 0, 32'h0);
        send("R8 real exact FFFFh", 1, 1, 7, 0, 0, 0, 32'h800F);
        send("R8 real 10000h", 1, 1, 7, 0, 0, 0, 32'h8010);
        send("R8 real carry past 32 bits", 1, 1, 2, 0, 0, 0, 32'h2);
        send("R9 protected wrap", 0, 1, 2, 1, 6, 0, 32'h2);
        send("R9 protected x8 wrap", 0, 1, 0, 1, 2, 3, 32'h0);
        idle(1);
        @(negedge clk);
        held = res_offset;
        idle(3);
        @(negedge clk);
        // R10 outputs hold while idle
        check("R10 hold offset", 64'(res_offset), 64'(held));
        check("R10 valid low idle", 64'(res_valid), 0);
        check("R10 queue drained", 64'(q.size()), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule